// File: doc/BRIEF.md
# Serial Character Transmitter with Sentinel Completion

This block takes one character from a parallel CPU output bus and sends it on a serial teletype line, one bit for each bit-time tick. A load strobe, accepted only while the block is idle, places the character in a shift buffer and drives a space on the line, which serves as the start bit. Each tick while the block is busy shifts the buffer one place toward the line flip-flop. On the first shift a single one is written into the top of the buffer, and every later shift writes a zero there. The block finds the end of the character when every buffer position above the lowest one reads zero. It does this with a zero-pattern test and keeps no bit counter.

Once shifting stops, the line stays at mark for a stop phase of a fixed number of ticks. Busy then clears and ready returns. The CPU can poll ready and busy as two separate condition flags. A mode-change command issued while idle starts a dummy cycle. The dummy cycle sets busy, forces the line to mark and clears the buffer, so the end pattern is true at once and only the stop phase runs. This gives the terminal time to switch from input to output.

Top module: `sertx_sentinel`

## Requirements
- R1: After reset, busy is 0, ready is 1 and the line output is 1 (mark).
- R2: A load strobe while busy is 0 and the mode command is low causes the following, seen in the next cycle: busy is 1, ready is 0 and the line is 0 (start bit). At all times ready equals the inverse of busy.
- R3: The first DATA_W ticks after a load drive the character bits onto the line, least significant bit first. Tick DATA_W+1 drives a 1 (stop bit). Each new line value appears in the cycle after its tick.
- R4: After DATA_W+1 shifting ticks the buffer holds only the marker at its lowest position. Later ticks do not shift, and the line stays at 1.
- R5: After shifting ends, STOP_TICKS further ticks are counted. On the last of them busy clears and ready sets, seen in the next cycle. A character therefore keeps busy for exactly DATA_W+1+STOP_TICKS ticks.
- R6: A load strobe while busy is 1 is ignored. The line sequence and the busy duration are unchanged.
- R7: A mode command while busy is 0 sets busy and drives the line to 1 in the next cycle. Busy clears after exactly STOP_TICKS ticks, and the line stays at 1 throughout.
- R8: A mode command while busy is 1 is ignored. If a mode command and a load strobe arrive in the same idle cycle, the mode command wins and the load data is discarded.
- R9: Ticks while busy is 0 have no effect. Busy stays 0 and the line stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle bit-time pulse |
| load_strobe | input | 1 | Output-transfer strobe for the character |
| load_data | input | DATA_W | Character from the CPU output bus |
| mode_cmd | input | 1 | Mode-change command; starts a dummy cycle |
| line_out | output | 1 | Serial line, 1 = mark, 0 = space |
| busy | output | 1 | Busy flag |
| ready | output | 1 | Ready flag |

## Verification
The bench builds the block with DATA_W = 8 and STOP_TICKS = 3. The non-default stop length shows that the stop phase follows its parameter and is not fixed at two ticks, both after a character and in the dummy cycle. Tick spacing varies from every cycle to every few cycles, which exercises end detection when ticks arrive back to back. Characters of all zeros, all ones and single set bits at either end place the marker next to data of both values, so a decode that looked at the wrong buffer positions would stop early or late.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_XMIT  = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;
endpackage

// File: rtl/sertx_shreg.sv
module sertx_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_char,
  input  logic              start_dummy,
  input  logic              shift_fire,
  input  logic [DATA_W-1:0] load_data,
  output logic              line_q,
  output logic              end_pat
);
  localparam int BUF_W = DATA_W + 1;

  logic [BUF_W-1:0] buf_q;
  logic             first_q;

  // True once only the bottom position may be nonzero.
  function automatic logic tail_empty(input logic [BUF_W-1:0] b);
    return ~|b[BUF_W-1:1];
  endfunction

  // Move one place toward the line, entering ins at the top.
  function automatic logic [BUF_W-1:0] shift_down(input logic [BUF_W-1:0] b,
                                                  input logic ins);
    return {ins, b[BUF_W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      line_q  <= 1'b1;
      first_q <= 1'b0;
    end else if (start_dummy) begin
      buf_q   <= '0;
      line_q  <= 1'b1;
      first_q <= 1'b0;
    end else if (start_char) begin
      buf_q   <= {1'b1, load_data};
      line_q  <= 1'b0;
      first_q <= 1'b1;
    end else if (shift_fire) begin
      line_q  <= buf_q[0];
      buf_q   <= shift_down(buf_q, first_q);
      first_q <= 1'b0;
    end
  end

  assign end_pat = tail_empty(buf_q);
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int STOP_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start_req,
  input  logic end_pat,
  input  logic line_mark,
  output logic busy,
  output logic ready,
  output logic shift_fire,
  output logic done_fire
);
  localparam int CNT_W = $clog2(STOP_TICKS + 1);

  phase_e     phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic       stop_tick;
  logic       last_stop;

  always_comb begin
    shift_fire = tick && (phase_q == PH_XMIT) && !end_pat;
    stop_tick  = tick && (phase_q != PH_IDLE) && end_pat && line_mark;
    if (phase_q == PH_XMIT) last_stop = (STOP_TICKS == 1);
    else                    last_stop = (cnt_q == CNT_W'(STOP_TICKS - 1));
    done_fire  = stop_tick && last_stop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ready   <= 1'b1;
    end else if (start_req) begin
      phase_q <= PH_XMIT;
      cnt_q   <= '0;
      ready   <= 1'b0;
    end else if (done_fire) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ready   <= 1'b1;
    end else if (stop_tick) begin
      phase_q <= PH_HOLD;
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign busy = (phase_q != PH_IDLE);
endmodule

// File: rtl/sertx_sentinel.sv
module sertx_sentinel #(
  parameter int DATA_W     = 8,
  parameter int STOP_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_strobe,
  input  logic [DATA_W-1:0] load_data,
  input  logic              mode_cmd,
  output logic              line_out,
  output logic              busy,
  output logic              ready
);
  logic start_char;
  logic start_dummy;
  logic start_req;
  logic shift_fire;
  logic done_fire;
  logic end_pat;

  // Commands are taken only while idle; mode command has priority.
  assign start_dummy = mode_cmd && !busy;
  assign start_char  = load_strobe && !busy && !mode_cmd;
  assign start_req   = start_dummy || start_char;

  sertx_ctrl #(.STOP_TICKS(STOP_TICKS)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .start_req  (start_req),
    .end_pat    (end_pat),
    .line_mark  (line_out),
    .busy       (busy),
    .ready      (ready),
    .shift_fire (shift_fire),
    .done_fire  (done_fire)
  );

  sertx_shreg #(.DATA_W(DATA_W)) shreg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_char  (start_char),
    .start_dummy (start_dummy),
    .shift_fire  (shift_fire),
    .load_data   (load_data),
    .line_q      (line_out),
    .end_pat     (end_pat)
  );
endmodule

// File: rtl/sertx_sentinel_chk.sv
module sertx_sentinel_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic load_strobe,
  input logic mode_cmd,
  input logic busy,
  input logic ready,
  input logic line_out,
  input logic end_pat,
  input logic start_char,
  input logic start_dummy,
  input logic done_fire
);
  // R2
  ready_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready == !busy);

  // R2
  char_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_char |=> busy && !ready && !line_out);

  // R4
  end_hold_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && end_pat && !start_char |=> line_out);

  // R5
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire |=> !busy && ready && line_out);

  // R6
  load_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && load_strobe && !tick |=> $stable(line_out) && busy);

  // R7
  dummy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_dummy |=> busy && line_out);

  // R8
  mode_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cmd && load_strobe && !busy |=> line_out);

  // R9
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && tick && !load_strobe && !mode_cmd |=> !busy && line_out);

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_out);
endmodule

bind sertx_sentinel sertx_sentinel_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .load_strobe (load_strobe),
  .mode_cmd    (mode_cmd),
  .busy        (busy),
  .ready       (ready),
  .line_out    (line_out),
  .end_pat     (end_pat),
  .start_char  (start_char),
  .start_dummy (start_dummy),
  .done_fire   (done_fire)
);

// File: tb/sertx_sentinel_tb_top.sv
module sertx_sentinel_tb_top;
  localparam int DW   = 8;
  localparam int STOP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          load_strobe = 1'b0;
  logic [DW-1:0] load_data = '0;
  logic          mode_cmd = 1'b0;
  logic          line_out, busy, ready;

  always #2 clk = ~clk;

  sertx_sentinel #(.DATA_W(DW), .STOP_TICKS(STOP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_strobe(load_strobe),
    .load_data(load_data), .mode_cmd(mode_cmd),
    .line_out(line_out), .busy(busy), .ready(ready)
  );

  int    total = 0;
  int    bad = 0;
  string tag = "R1";
  bit    done_run = 0;

  // Behavioural reference model
  bit    m_busy = 0;
  bit    m_line = 1;
  bit    q[$];
  int    stop_left = 0;
  int    busy_ticks = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_line = 1; q.delete(); stop_left = 0;
    end else if (!m_busy) begin
      if (mode_cmd) begin
        m_busy = 1; m_line = 1; q.delete(); stop_left = STOP; busy_ticks = 0;
      end else if (load_strobe) begin
        m_busy = 1; m_line = 0; q.delete();
        for (int i = 0; i < DW; i++) q.push_back(load_data[i]);
        q.push_back(1'b1);
        stop_left = STOP; busy_ticks = 0;
      end
    end else if (tick) begin
      busy_ticks++;
      if (q.size() > 0) m_line = q.pop_front();
      else begin
        stop_left--;
        if (stop_left == 0) m_busy = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // Compare with the model every cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      chk(line_out == m_line, {tag, " line"}, line_out, m_line);
      chk(busy == m_busy, {tag, " busy"}, busy, m_busy);
      chk(ready == !m_busy, "R2 ready", ready, !m_busy);
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done_run) begin
      done_run = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic run_ticks(input int gap);
    while (busy) begin
      cyc(gap);
      do_tick();
    end
  endtask

  task automatic send(input logic [DW-1:0] d, input int gap, input string t);
    tag = t;
    load_data = d; load_strobe = 1; @(negedge clk); load_strobe = 0;
    chk(busy && !line_out, "R2 start bit", line_out, 0);
    run_ticks(gap);
    // R5: busy held for DW+1+STOP ticks
    chk(busy_ticks == DW + 1 + STOP, "R5 tick count", busy_ticks, DW + 1 + STOP);
    chk(!busy && ready && line_out, "R4 idle mark", line_out, 1);
    cyc(2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && ready && line_out, "R1 reset", {busy, ready, line_out}, 3'b011);

    send(8'hA5, 2, "R3");
    send(8'h00, 0, "R3");
    send(8'hFF, 1, "R4");
    send(8'h01, 3, "R4");
    send(8'h80, 0, "R3");

    // R6: load while busy is ignored
    tag = "R6";
    load_data = 8'h3C; load_strobe = 1; @(negedge clk); load_strobe = 0;
    cyc(1); do_tick(); do_tick();
    load_data = 8'hC3; load_strobe = 1; @(negedge clk); load_strobe = 0;
    run_ticks(1);
    chk(busy_ticks == DW + 1 + STOP, "R6 tick count", busy_ticks, DW + 1 + STOP);
    cyc(2);

    // R7: dummy cycle
    tag = "R7";
    mode_cmd = 1; @(negedge clk); mode_cmd = 0;
    chk(busy && line_out, "R7 dummy start", {busy, line_out}, 2'b11);
    run_ticks(2);
    chk(busy_ticks == STOP, "R7 tick count", busy_ticks, STOP);
    cyc(2);

    // R8: mode while busy ignored
    tag = "R8";
    load_data = 8'h5A; load_strobe = 1; @(negedge clk); load_strobe = 0;
    do_tick();
    mode_cmd = 1; @(negedge clk); mode_cmd = 0;
    chk(busy && line_out == 1'b0, "R8 no restart", line_out, 0);
    run_ticks(0);
    chk(busy_ticks == DW + 1 + STOP, "R8 tick count", busy_ticks, DW + 1 + STOP);
    cyc(2);

    // R8: mode wins over load in the same cycle
    load_data = 8'h00; load_strobe = 1; mode_cmd = 1;
    @(negedge clk); load_strobe = 0; mode_cmd = 0;
    chk(busy && line_out, "R8 mode priority", line_out, 1);
    run_ticks(1);
    chk(busy_ticks == STOP, "R8 priority ticks", busy_ticks, STOP);
    cyc(2);

    // R9: idle ticks ignored
    tag = "R9";
    for (int k = 0; k < 5; k++) do_tick();
    chk(!busy && line_out, "R9 idle ticks", {busy, line_out}, 2'b01);

    send(8'h96, 4, "R3");

    done_run = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule